// File: doc/BRIEF.md
# Gated Programmable Clock Divider with Duty Control

The block derives a slower clock, such as a serial-audio bit clock or a left/right frame clock, from a fast input clock by counting input cycles. A ratio field sets the length of each output period as the field value plus one input cycles. The field value zero means "off": the output stays low and the internal count rests at zero, ready for a clean restart.

A parameter chooses between two waveform shapes. The plain shape gives a nominal half-duty square wave. The duty shape adds a high-time field that fixes how many input cycles of each period are high, so a frame clock can be given any duty cycle the period length allows. New field values take effect only at a period boundary, or at once when the output is gated, so a write in the middle of a period never yields a runt pulse. A status output shows whether the ratio field is non-zero.

Top module: `frame_clk_div`

## Requirements
- R1: With a ratio field value N from 1 to 2^DIV_W-1, each output period lasts exactly N+1 input clock cycles (ratio 2 up to 16 with DIV_W=4).
- R2: A ratio field value of 0 gates the output: it stays low and the period count is held at zero. When a non-zero value is then sampled at a rising input clock edge, the output is high right after that edge and starts a full new period.
- R3: In the duty shape (HAS_DUTY=1), with high-time field H and ratio field N, the output is high for the first H+1 cycles of each period and low for the remaining N-H cycles; with H >= N the output stays high constantly.
- R4: In the plain shape (HAS_DUTY=0), the output is high for the first floor((N+1)/2) cycles of each period and low for the rest; the high-time field has no effect.
- R5: Field values are sampled only in the last input cycle of a period (or in any cycle while gated); a period already under way finishes with its old ratio and high time.
- R6: The status output is 1 from the clock edge after which the ratio field was sampled non-zero, and 0 one edge after it was sampled zero.
- R7: While reset is high, the output clock and the status output are both low, whatever the fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_fld | input | DIV_W | Ratio field; period is value+1 cycles, 0 gates |
| hightime_fld | input | DIV_W | High-time field; high for value+1 cycles (duty shape only) |
| div_clk | output | 1 | Divided output clock, registered |
| div_en | output | 1 | Status: ratio field non-zero, registered |

## Verification
The bench builds two copies with DIV_W=4, one with the duty shape and one with the plain shape, driven from the same fields. The narrow field keeps the widest ratio at 16 cycles, so every ratio from the minimum of 2 to the maximum, odd and even ratios for the half-duty rounding, and the high time reaching the full period all fit in short runs. Mid-period rewrites and gating then restarting are checked on both shapes by counting high and low runs at the output.

// File: rtl/frame_clk_div_pkg.sv
package frame_clk_div_pkg;

  // Number of high cycles of the plain shape for a period of the given length.
  function automatic int half_span(input int period_len);
    return period_len / 2;
  endfunction

endpackage

// File: rtl/frame_clk_div_ctrl.sv
// Period counter with boundary-only loading of the ratio and high-time fields.
module frame_clk_div_ctrl #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ratio_in,
  input  logic [DIV_W-1:0] high_in,
  output logic [DIV_W-1:0] cnt_q,
  output logic [DIV_W-1:0] ratio_q,
  output logic [DIV_W-1:0] high_q,
  output logic [DIV_W-1:0] cnt_d,
  output logic [DIV_W-1:0] ratio_d,
  output logic [DIV_W-1:0] high_d
);

  logic boundary;

  assign boundary = (ratio_q == '0) || (cnt_q == ratio_q);

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    ratio_d = ratio_q;
    high_d  = high_q;
    if (boundary) begin
      cnt_d   = '0;
      ratio_d = ratio_in;
      high_d  = high_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      high_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      high_q  <= high_d;
    end
  end

endmodule

// File: rtl/frame_clk_div_shape.sv
// Output level for a given period position; the parameter picks the shape.
module frame_clk_div_shape
  import frame_clk_div_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter bit HAS_DUTY = 1'b1
) (
  input  logic [DIV_W-1:0] cnt,
  input  logic [DIV_W-1:0] ratio,
  input  logic [DIV_W-1:0] high,
  output logic             level
);

  logic running;
  assign running = (ratio != '0);

  generate
    if (HAS_DUTY) begin : g_duty
      assign level = running && (cnt <= high);
    end else begin : g_half
      logic unused_high;
      assign unused_high = ^high;
      assign level = running && (int'(cnt) < half_span(int'(ratio) + 1));
    end
  endgenerate

endmodule

// File: rtl/frame_clk_div.sv
module frame_clk_div #(
  parameter int DIV_W    = 4,
  parameter bit HAS_DUTY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ratio_fld,
  input  logic [DIV_W-1:0] hightime_fld,
  output logic             div_clk,
  output logic             div_en
);

  logic [DIV_W-1:0] cnt_q, ratio_q, high_q;
  logic [DIV_W-1:0] cnt_d, ratio_d, high_d;
  logic             level_d;
  logic             clk_q, en_q;

  frame_clk_div_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ratio_in (ratio_fld),
    .high_in  (hightime_fld),
    .cnt_q    (cnt_q),
    .ratio_q  (ratio_q),
    .high_q   (high_q),
    .cnt_d    (cnt_d),
    .ratio_d  (ratio_d),
    .high_d   (high_d)
  );

  frame_clk_div_shape #(.DIV_W(DIV_W), .HAS_DUTY(HAS_DUTY)) u_shape (
    .cnt   (cnt_d),
    .ratio (ratio_d),
    .high  (high_d),
    .level (level_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      clk_q <= level_d;
      en_q  <= (ratio_fld != '0);
    end
  end

  assign div_clk = clk_q;
  assign div_en  = en_q;

endmodule

// File: rtl/frame_clk_div_chk.sv
module frame_clk_div_chk #(
  parameter int DIV_W    = 4,
  parameter bit HAS_DUTY = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] ratio_fld,
  input logic [DIV_W-1:0] cnt_q,
  input logic [DIV_W-1:0] ratio_q,
  input logic [DIV_W-1:0] high_q,
  input logic             div_clk,
  input logic             div_en
);

  // R2: gated output is low and count rests at zero
  a_r2_gated_low: assert property (@(posedge clk) disable iff (rst)
    (ratio_q == '0) |-> (!div_clk && cnt_q == '0));

  // R1: count never passes the period end and wraps to zero after it
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != '0) |-> (cnt_q <= ratio_q));
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != '0 && cnt_q == ratio_q) |=> (cnt_q == '0));

  // R5: settings hold for the whole period
  a_r5_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != '0 && cnt_q != ratio_q) |=> ($stable(ratio_q) && $stable(high_q)));

  // R6: status follows the ratio field one edge later
  a_r6_status: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (div_en == ($past(ratio_fld) != '0)));

  // R2: each period starts high
  a_r2_start_high: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != '0 && cnt_q == '0) |-> div_clk);

  generate
    if (HAS_DUTY) begin : g_duty_chk
      // R3: high exactly while inside the high window
      a_r3_duty_window: assert property (@(posedge clk) disable iff (rst)
        (ratio_q != '0) |-> (div_clk == (cnt_q <= high_q)));
    end
  endgenerate

endmodule

bind frame_clk_div frame_clk_div_chk #(.DIV_W(DIV_W), .HAS_DUTY(HAS_DUTY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ratio_fld (ratio_fld),
  .cnt_q     (cnt_q),
  .ratio_q   (ratio_q),
  .high_q    (high_q),
  .div_clk   (div_clk),
  .div_en    (div_en)
);

// File: tb/frame_clk_div_bench.sv
`timescale 1ns/1ps
module frame_clk_div_bench;

  localparam int W = 4;
  localparam int NV = 10;
  // each entry: {ratio field, high-time field}, all with high < ratio
  localparam int VEC [NV][2] = '{
    '{1, 0}, '{2, 0}, '{2, 1}, '{3, 1}, '{4, 2},
    '{7, 0}, '{15, 14}, '{15, 7}, '{6, 5}, '{5, 3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] ratio_fld = '0;
  logic [W-1:0] hightime_fld = '0;
  logic q_duty, q_half, en_duty, en_half;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  frame_clk_div #(.DIV_W(W), .HAS_DUTY(1'b1)) u_frame_clk_div (
    .clk(clk), .rst(rst), .ratio_fld(ratio_fld), .hightime_fld(hightime_fld),
    .div_clk(q_duty), .div_en(en_duty));

  frame_clk_div #(.DIV_W(W), .HAS_DUTY(1'b0)) u_frame_clk_div_half (
    .clk(clk), .rst(rst), .ratio_fld(ratio_fld), .hightime_fld(hightime_fld),
    .div_clk(q_half), .div_en(en_half));

  function automatic logic sel(input bit half);
    return half ? q_half : q_duty;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count consecutive cycles (from now) at the given level
  task automatic run_len(input bit half, input logic lvl, output int n);
    n = 0;
    while (sel(half) == lvl && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  // align on a rising output edge, then measure one high and one low run
  task automatic measure(input bit half, output int hc, output int lc);
    int skip;
    run_len(half, 1'b1, skip);
    run_len(half, 1'b0, skip);
    run_len(half, 1'b1, hc);
    run_len(half, 1'b0, lc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hc, lc, n;
    // R7: reset holds outputs low even with a non-zero field
    ratio_fld = 4'd5;
    repeat (4) @(negedge clk);
    check("R7 clk low in reset", q_duty, 0);
    check("R7 status low in reset", en_duty, 0);
    check("R7 plain clk low in reset", q_half, 0);
    ratio_fld = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R1 R3 R4: table of ratios and high times
    for (int i = 0; i < NV; i++) begin
      ratio_fld = W'(VEC[i][0]);
      hightime_fld = W'(VEC[i][1]);
      measure(1'b0, hc, lc);
      measure(1'b0, hc, lc);
      check($sformatf("R3 high run ratio=%0d", VEC[i][0] + 1), hc, VEC[i][1] + 1);
      check($sformatf("R1 period ratio=%0d", VEC[i][0] + 1), hc + lc, VEC[i][0] + 1);
      measure(1'b1, hc, lc);
      check($sformatf("R4 high run ratio=%0d", VEC[i][0] + 1), hc, (VEC[i][0] + 1) / 2);
      check($sformatf("R1 plain period ratio=%0d", VEC[i][0] + 1), hc + lc, VEC[i][0] + 1);
    end

    // R3: high time at or beyond the ratio keeps the output high
    ratio_fld = 4'd4;
    hightime_fld = 4'd4;
    repeat (12) @(negedge clk);
    run_len(1'b0, 1'b1, n);
    check("R3 constant high when high>=ratio", n, 100);
    measure(1'b1, hc, lc);
    check("R4 high field ignored (high run)", hc, 2);
    check("R4 high field ignored (low run)", lc, 3);

    // R5: mid-period rewrite completes the running period first
    ratio_fld = 4'd9;
    hightime_fld = 4'd4;
    measure(1'b0, hc, lc);
    measure(1'b0, hc, lc);
    // now in the first high cycle of a fresh period
    ratio_fld = 4'd3;
    hightime_fld = 4'd0;
    run_len(1'b0, 1'b1, hc);
    run_len(1'b0, 1'b0, lc);
    check("R5 old high run kept", hc, 5);
    check("R5 old low run kept", lc, 5);
    run_len(1'b0, 1'b1, hc);
    run_len(1'b0, 1'b0, lc);
    check("R5 new high run", hc, 1);
    check("R5 new low run", lc, 3);

    // R6: status follows the field
    check("R6 status on", en_duty, 1);
    ratio_fld = '0;
    @(negedge clk);
    check("R6 status off", en_duty, 0);
    check("R6 plain status off", en_half, 0);

    // R2: gated output stays low
    repeat (20) @(negedge clk);
    n = 0;
    for (int k = 0; k < 30; k++) begin
      if (q_duty || q_half) n++;
      @(negedge clk);
    end
    check("R2 gated output low", n, 0);

    // R2: restart is immediate and clean
    ratio_fld = 4'd3;
    hightime_fld = 4'd1;
    @(negedge clk);
    check("R2 restart high", q_duty, 1);
    check("R6 status on after restart", en_duty, 1);
    run_len(1'b0, 1'b1, hc);
    run_len(1'b0, 1'b0, lc);
    check("R2 restart high run", hc, 2);
    check("R2 restart low run", lc, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule